// File: doc/BRIEF.md
# Bit-Band Alias Bridge

This block is a bus slave that sits on an alias window of 32 MiB. Each 32-bit word in the window stands for a single bit of a backing memory region. A read from an alias word returns that one bit as 0 or 1. A write to an alias word performs a read-modify-write on the backing memory. The write sets or clears only the addressed bit and leaves every other bit of the backing unit as it was.

The size of the access (byte, halfword or word) selects the backing unit. The size also sets how many alias offset bits form the bit index and how the backing address is aligned. The window and the backing region are both parameters. One instance can map `0x2200_0000` onto `0x2000_0000`, and a second instance can map `0x4200_0000` onto `0x4000_0000`.

An access outside the window is not claimed. The `s_hit` flag stays low, so the surrounding interconnect can route the access elsewhere. The bridge leaves such an access alone.

Top module: `bitband_bridge`

## Requirements
- R1: While reset is held and in the cycle after it is released, `s_ready`, `m_rd` and `m_wr` are low.
- R2: `s_hit` is 1 exactly when `s_addr[31:25]` equals `ALIAS_BASE[31:25]`. A request with `s_hit` low starts no backing access and never raises `s_ready`.
- R3: The backing address on `m_addr` is `BACKING_BASE` ORed with alias offset bits [24:5] placed at bits [19:0]. It is then aligned as stated in R4 to R6.
- R4: For a byte access (`s_size`=0), the bit index is offset bits [4:2]. The backing address is not further aligned.
- R5: For a halfword access (`s_size`=1), the bit index is offset bits [5:2]. Bit 0 of the backing address is cleared.
- R6: For a word access (`s_size`=2 or 3), the bit index is offset bits [6:2]. Bits [1:0] of the backing address are cleared, and `m_size` is 2.
- R7: A read returns the selected backing bit in `s_rdata[0]`, and `s_rdata[31:1]` is zero.
- R8: A write issues one backing read and then one backing write of the same unit and size. The selected bit equals `s_wdata[0]`, and every other bit of the unit is preserved.
- R9: A read access issues no backing write. `m_rd` and `m_wr` are never high in the same cycle, and `m_addr` is stable while a backing phase waits.
- R10: The backing unit is carried right-justified in `m_rdata`/`m_wdata`. Bytes are ordered little-endian, so bit n of the unit lives at backing byte address + n/8.
- R11: `s_ready` is a one-cycle pulse. It comes at least one cycle after the backing read completes, and a read access takes four cycles from request to ready with a one-cycle memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_req | input | 1 | Request, held until `s_ready` |
| s_we | input | 1 | 1 = write, 0 = read |
| s_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| s_addr | input | 32 | Alias byte address |
| s_wdata | input | 32 | Write data, bit 0 used |
| s_hit | output | 1 | Address falls inside the alias window |
| s_ready | output | 1 | Access complete pulse |
| s_rdata | output | 32 | Selected bit in bit 0 |
| m_rd | output | 1 | Backing read phase, held until `m_rvalid` |
| m_wr | output | 1 | Backing write phase, held until `m_wack` |
| m_size | output | 2 | Backing unit size |
| m_addr | output | 32 | Backing byte address |
| m_wdata | output | 32 | Modified unit, right-justified |
| m_rdata | input | 32 | Backing unit, right-justified |
| m_rvalid | input | 1 | Backing read data valid |
| m_wack | input | 1 | Backing write accepted |

## Verification
Suppose the latched bit index, size or address is wrong. The error shows up at the ports on that very access: `s_rdata[0]` carries a neighbouring bit, or the write-back flips a foreign bit of backing memory. The bench catches a foreign bit by comparing the entire memory image after every write. A state machine that skips or repeats a phase shows up as a stray backing write on a read, a missing write-back, or a `s_ready` pulse that comes early or lasts two cycles. All of these are visible within the few cycles of one access.

// File: rtl/bitband_bridge.sv
module bitband_bridge #(
  parameter logic [31:0] ALIAS_BASE   = 32'h2200_0000,
  parameter logic [31:0] BACKING_BASE = 32'h2000_0000,
  parameter int          WIN_BITS     = 25
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        s_req,
  input  logic        s_we,
  input  logic [1:0]  s_size,
  input  logic [31:0] s_addr,
  input  logic [31:0] s_wdata,
  output logic        s_hit,
  output logic        s_ready,
  output logic [31:0] s_rdata,
  output logic        m_rd,
  output logic        m_wr,
  output logic [1:0]  m_size,
  output logic [31:0] m_addr,
  output logic [31:0] m_wdata,
  input  logic [31:0] m_rdata,
  input  logic        m_rvalid,
  input  logic        m_wack
);
  localparam int SHIFTED = WIN_BITS - 5;

  typedef enum logic [2:0] {ST_IDLE, ST_RD, ST_MOD, ST_WR, ST_DONE} st_t;

  st_t         st;
  logic [31:0] addr_q, unit_q, raw_addr, algn_addr, lane_mask;
  logic [4:0]  idx_q, idx_d;
  logic [1:0]  size_q, size_n;
  logic        we_q, set_q, bit_q;

  wire [WIN_BITS-1:0] off = s_addr[WIN_BITS-1:0];

  assign s_hit    = s_addr[31:WIN_BITS] == ALIAS_BASE[31:WIN_BITS];
  assign raw_addr = BACKING_BASE | {{(32-SHIFTED){1'b0}}, off[WIN_BITS-1:5]};
  assign size_n   = (s_size == 2'd3) ? 2'd2 : s_size;

  always_comb begin
    case (size_n)
      2'd0:    begin algn_addr = raw_addr;                idx_d = {2'b00, off[4:2]}; end
      2'd1:    begin algn_addr = {raw_addr[31:1], 1'b0};  idx_d = {1'b0, off[5:2]};  end
      default: begin algn_addr = {raw_addr[31:2], 2'b00}; idx_d = off[6:2];          end
    endcase
  end

  always_comb begin
    case (size_q)
      2'd0:    lane_mask = 32'h0000_00FF;
      2'd1:    lane_mask = 32'h0000_FFFF;
      default: lane_mask = 32'hFFFF_FFFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      addr_q <= '0;
      unit_q <= '0;
      idx_q  <= '0;
      size_q <= '0;
      we_q   <= 1'b0;
      set_q  <= 1'b0;
      bit_q  <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (s_req && s_hit) begin
          addr_q <= algn_addr;
          size_q <= size_n;
          idx_q  <= idx_d;
          we_q   <= s_we;
          set_q  <= s_wdata[0];
          st     <= ST_RD;
        end
        ST_RD: if (m_rvalid) begin
          unit_q <= m_rdata & lane_mask;
          bit_q  <= m_rdata[idx_q];
          st     <= ST_MOD;
        end
        ST_MOD: begin
          if (we_q) begin
            unit_q <= set_q ? (unit_q | (32'd1 << idx_q)) : (unit_q & ~(32'd1 << idx_q));
            st     <= ST_WR;
          end else begin
            st <= ST_DONE;
          end
        end
        ST_WR:   if (m_wack) st <= ST_DONE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign m_rd    = st == ST_RD;
  assign m_wr    = st == ST_WR;
  assign m_addr  = addr_q;
  assign m_size  = size_q;
  assign m_wdata = unit_q;
  assign s_ready = st == ST_DONE;
  assign s_rdata = {31'b0, bit_q};
endmodule

module bitband_bridge_chk #(
  parameter logic [31:0] BACKING_BASE = 32'h2000_0000
) (
  input logic        clk,
  input logic        rst_n,
  input logic        s_req,
  input logic        s_we,
  input logic        s_hit,
  input logic        s_ready,
  input logic [31:0] s_rdata,
  input logic        m_rd,
  input logic        m_wr,
  input logic [1:0]  m_size,
  input logic [31:0] m_addr,
  input logic        m_rvalid,
  input logic        m_wack
);
  assert_idle_in_reset_R1: assert property (@(posedge clk)
    !rst_n |=> (!s_ready && !m_rd && !m_wr));

  assert_claim_needs_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_rd) |-> $past(s_hit));

  assert_backing_region_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rd || m_wr) |-> (m_addr[31:20] == BACKING_BASE[31:20]));

  assert_half_align_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_rd || m_wr) && m_size == 2'd1) |-> !m_addr[0]);

  assert_word_align_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_rd || m_wr) && m_size == 2'd2) |-> (m_addr[1:0] == 2'b00));

  assert_rdata_one_bit_R7: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> (s_rdata[31:1] == 31'b0));

  assert_write_only_on_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
    m_wr |-> s_we);

  assert_phases_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(m_rd && m_wr));

  assert_addr_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((m_rd && !m_rvalid) || (m_wr && !m_wack)) |=> $stable(m_addr));

  assert_ready_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);

  assert_ready_after_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (m_rd && m_rvalid) |=> !s_ready);
endmodule

bind bitband_bridge bitband_bridge_chk #(.BACKING_BASE(BACKING_BASE)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_req(s_req), .s_we(s_we), .s_hit(s_hit),
  .s_ready(s_ready), .s_rdata(s_rdata), .m_rd(m_rd), .m_wr(m_wr),
  .m_size(m_size), .m_addr(m_addr), .m_rvalid(m_rvalid), .m_wack(m_wack)
);

// File: tb/bitband_bridge_test.sv
module bitband_bridge_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic s_req = 1'b0, s_we = 1'b0;
  logic [1:0] s_size = '0;
  logic [31:0] s_addr = '0, s_wdata = '0;
  logic s_hit, s_ready, m_rd, m_wr, m_rvalid = 1'b0, m_wack = 1'b0;
  logic [31:0] s_rdata, m_addr, m_wdata, m_rdata = '0;
  logic [1:0] m_size;

  int checks = 0, failures = 0;
  int rd_cnt = 0, wr_cnt = 0;
  logic [31:0] last_rd_addr = '0;
  logic [7:0] mem [256];
  logic [7:0] shadow [256];

  always #2 clk = ~clk;

  bitband_bridge uut (.*);

  function automatic int nbytes(input logic [1:0] sz);
    return sz == 2'd0 ? 1 : (sz == 2'd1 ? 2 : 4);
  endfunction

  always @(posedge clk) begin
    m_rvalid <= m_rd && !m_rvalid;
    m_wack   <= m_wr && !m_wack;
    if (m_rd && !m_rvalid) begin
      logic [31:0] u;
      u = '0;
      for (int i = 0; i < nbytes(m_size); i++) u[8*i +: 8] = mem[8'(m_addr[7:0] + i)];
      m_rdata      <= u;
      last_rd_addr <= m_addr;
      rd_cnt       <= rd_cnt + 1;
    end
    if (m_wr && !m_wack) begin
      for (int i = 0; i < nbytes(m_size); i++) mem[8'(m_addr[7:0] + i)] <= m_wdata[8*i +: 8];
      wr_cnt <= wr_cnt + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    @(negedge clk);
    s_req = 1'b1; s_we = we; s_size = sz; s_addr = a; s_wdata = wd;
    cyc = 0;
    do begin @(negedge clk); cyc++; end while (!s_ready);
    rd = s_rdata;
    s_req = 1'b0;
  endtask

  function automatic logic [31:0] exp_addr(input logic [1:0] sz, input logic [31:0] off);
    logic [31:0] a;
    a = 32'h2000_0000 | ((off & 32'h01FF_FFFF) >> 5);
    if (sz == 2'd1) a[0] = 1'b0;
    if (sz >= 2'd2) a[1:0] = 2'b00;
    return a;
  endfunction

  function automatic int exp_idx(input logic [1:0] sz, input logic [31:0] off);
    return sz == 2'd0 ? int'((off >> 2) % 8) : (sz == 2'd1 ? int'((off >> 2) % 16) : int'((off >> 2) % 32));
  endfunction

  function automatic bit shadow_bit(input logic [31:0] a, input int idx);
    return shadow[8'(a[7:0] + idx / 8)][idx % 8];
  endfunction

  function automatic bit mem_match();
    for (int i = 0; i < 256; i++) if (mem[i] !== shadow[i]) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    #400000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] rd, ea;
    int cyc, idx, r0, w0;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i * 37 + 5); shadow[i] = 8'(i * 37 + 5); end
    repeat (3) @(negedge clk);
    check(!s_ready && !m_rd && !m_wr, "R1 reset outputs", {29'b0, s_ready, m_rd, m_wr}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!s_ready && !m_rd && !m_wr, "R1 after release", {29'b0, s_ready, m_rd, m_wr}, 32'h0);

    s_addr = 32'h21FF_FFFC; #0;
    check(s_hit == 1'b0, "R2 below window", {31'b0, s_hit}, 32'h0);
    s_addr = 32'h2200_0000; #0;
    check(s_hit == 1'b1, "R2 window start", {31'b0, s_hit}, 32'h1);
    s_addr = 32'h23FF_FFFC; #0;
    check(s_hit == 1'b1, "R2 window end", {31'b0, s_hit}, 32'h1);
    s_addr = 32'h2400_0000; #0;
    check(s_hit == 1'b0, "R2 above window", {31'b0, s_hit}, 32'h0);
    s_addr = 32'h4200_0000; #0;
    check(s_hit == 1'b0, "R2 other instance window", {31'b0, s_hit}, 32'h0);

    r0 = rd_cnt;
    begin
      int seen;
      seen = 0;
      s_req = 1'b1; s_we = 1'b1; s_size = 2'd2; s_addr = 32'h2400_0010; s_wdata = 32'h1;
      for (int k = 0; k < 10; k++) begin @(negedge clk); if (s_ready) seen++; end
      s_req = 1'b0;
      check(seen == 0 && rd_cnt == r0 && mem_match(), "R2 unclaimed access ignored", 32'(seen), 32'h0);
    end

    for (int sz = 0; sz < 3; sz++) begin
      for (int w = 0; w < 128; w++) begin
        logic [31:0] off;
        off = 32'(w * 4);
        w0 = wr_cnt;
        access(1'b0, 2'(sz), 32'h2200_0000 + off, 32'hFFFF_FFFF, rd, cyc);
        ea = exp_addr(2'(sz), off);
        idx = exp_idx(2'(sz), off);
        check(last_rd_addr == ea, sz == 0 ? "R3 R4 byte address" : (sz == 1 ? "R3 R5 half address" : "R3 R6 word address"), last_rd_addr, ea);
        check(rd == {31'b0, shadow_bit(ea, idx)}, sz == 0 ? "R4 R10 byte bit" : (sz == 1 ? "R5 R10 half bit" : "R6 R10 word bit"), rd, {31'b0, shadow_bit(ea, idx)});
        check(rd[31:1] == 31'b0, "R7 upper read bits zero", rd, {31'b0, rd[0]});
        check(wr_cnt == w0, "R9 read issues no write", 32'(wr_cnt - w0), 32'h0);
        check(cyc == 4, "R11 read latency", 32'(cyc), 32'd4);
      end
    end

    access(1'b0, 2'd3, 32'h2200_0044, 32'h0, rd, cyc);
    check(last_rd_addr == 32'h2000_0000 && rd[0] == shadow_bit(32'h2000_0000, 17), "R6 size 3 as word", last_rd_addr, 32'h2000_0000);

    for (int sz = 0; sz < 3; sz++) begin
      for (int w = 0; w < 128; w++) begin
        logic [31:0] off;
        bit v;
        off = 32'(w * 4);
        v = ((w * 7 + sz) % 3) == 0 ? ~shadow_bit(exp_addr(2'(sz), off), exp_idx(2'(sz), off)) : 1'(w % 2);
        r0 = rd_cnt; w0 = wr_cnt;
        access(1'b1, 2'(sz), 32'h2200_0000 + off, {31'h7FFF_FFFE, v}, rd, cyc);
        ea = exp_addr(2'(sz), off);
        idx = exp_idx(2'(sz), off);
        shadow[8'(ea[7:0] + idx / 8)][idx % 8] = v;
        check(rd_cnt == r0 + 1 && wr_cnt == w0 + 1, "R8 one read one write", 32'((rd_cnt - r0) * 16 + (wr_cnt - w0)), 32'h11);
        check(mem_match(), "R8 R10 memory after write", 32'(w), 32'(w));
      end
    end

    access(1'b1, 2'd2, 32'h23FF_FFFC, 32'h0, rd, cyc);
    shadow[8'hFF][7] = 1'b0;
    check(last_rd_addr == 32'h200F_FFFC && mem_match(), "R3 R6 top of window", last_rd_addr, 32'h200F_FFFC);
    access(1'b1, 2'd0, 32'h23FF_FFFC, 32'h1, rd, cyc);
    shadow[8'hFF][7] = 1'b1;
    check(last_rd_addr == 32'h200F_FFFF && mem_match(), "R3 R4 top byte set", last_rd_addr, 32'h200F_FFFF);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule